// File: doc/BRIEF.md
# Potentiometer Wiper Position Counter

This block holds the 6-bit tap position of one digitally controlled potentiometer and decodes it into a one-hot select for the 64 tap switches of the resistor string. Position 0 ties the wiper to the low terminal and position 63 ties it to the high terminal. The analog string and the serial bus framing sit outside the block. The framing logic tells the block when to load a value and when step mode is active.

The position changes in four ways. A synchronous reset loads the value of data register zero. A transfer strobe loads one of four data register values, which arrive together on a flat bus. A host write loads a value the host supplies. In step mode, each rising edge of the serial clock moves the wiper one tap. The serial data level sampled at that edge picks the direction: high moves the wiper toward the high terminal and low moves it toward the low terminal. The framing logic drops the step enable when the master issues STOP. Stepping saturates at both ends of the range.

The serial clock and data inputs are taken to be already synchronised to the block clock.

Top module: `wiper_counter_top`

## Requirements
- R1: While `rst_n` is low, each clock edge loads `wiper_pos` with data register zero, which is field `dreg_bus[5:0]`. That value remains after reset is released.
- R2: `tap_sel` has exactly one bit set, and that bit is bit number `wiper_pos`. Bit 0 selects the low terminal and bit 63 selects the high terminal.
- R3: A clock edge with `wr_en` high loads `wr_data` into `wiper_pos`.
- R4: A clock edge with `xfer_en` high loads data register `xfer_sel` into `wiper_pos`. Register k is field `dreg_bus[6k+5:6k]`.
- R5: When `step_en` is high, a low-to-high change of `scl` moves `wiper_pos` up by one if `sda` is 1 and down by one if `sda` is 0. The change is visible after the next clock edge.
- R6: A step up at 63 leaves the value at 63, and a step down at 0 leaves it at 0.
- R7: Each `scl` pulse gives at most one step, however long `scl` stays high. The direction is fixed by `sda` at the rising edge, and a later change of `sda` while `scl` is high has no effect.
- R8: `scl` pulses while `step_en` is low leave `wiper_pos` unchanged.
- R9: When more than one source acts in the same cycle, the priority is reset, then transfer, then host write, then step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset; loads data register zero |
| step_en | input | 1 | Step mode active; cleared by the framing logic on STOP |
| scl | input | 1 | Synchronised serial clock; its rising edges request steps |
| sda | input | 1 | Synchronised serial data; the step direction (1 = up) |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 6 | Host write value |
| xfer_en | input | 1 | Data register transfer strobe |
| xfer_sel | input | 2 | Index of the data register to transfer |
| dreg_bus | input | 24 | Four 6-bit data register values; register k is at bits 6k+5:6k |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch select |

## Verification
Directed step sequences approach each end of the range, so they show whether the counter saturates at 63 and 0 or wraps around. Long `scl` highs show whether one pulse can give more than one step. An `sda` flip while `scl` is high shows whether the direction is taken at the rising edge or later. Pulses with `step_en` low show whether step mode is honoured at all. Collision cases assert two or three load sources in the same cycle to expose the priority order. A seeded random mix of all operations, with random register contents, then checks the position and the tap decode against a model in the bench after every operation.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   // Source that updated the wiper position in a cycle
   typedef enum logic [2:0] {
      SRC_HOLD  = 3'd0,
      SRC_RESET = 3'd1,
      SRC_XFER  = 3'd2,
      SRC_WRITE = 3'd3,
      SRC_STEP  = 3'd4
   } wiper_src_e;
endpackage

// File: rtl/wiper_step_detect.sv
module wiper_step_detect (
   input  logic clk,
   input  logic scl,
   input  logic sda,
   input  logic step_en,
   output logic step_pulse,
   output logic step_up
);
   logic scl_q;

   // Track scl in every cycle, so that an scl already high when reset is released gives no step
   always_ff @(posedge clk) begin
      scl_q <= scl;
   end

   assign step_pulse = step_en & scl & ~scl_q;
   assign step_up    = sda;
endmodule

// File: rtl/wiper_dreg_mux.sv
module wiper_dreg_mux #(
   parameter int CNT_W    = 6,
   parameter int NUM_DREG = 4,
   localparam int SEL_W   = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1
) (
   input  logic [NUM_DREG*CNT_W-1:0] dreg_bus,
   input  logic [SEL_W-1:0]          sel,
   output logic [CNT_W-1:0]          sel_val,
   output logic [CNT_W-1:0]          zero_val
);
   logic [CNT_W-1:0] regs [NUM_DREG];

   for (genvar k = 0; k < NUM_DREG; k++) begin : g_unpack
      assign regs[k] = dreg_bus[k*CNT_W +: CNT_W];
   end

   always_comb begin
      sel_val = regs[0];
      for (int k = 0; k < NUM_DREG; k++) begin
         if (SEL_W'(k) == sel) sel_val = regs[k];
      end
   end

   assign zero_val = regs[0];
endmodule

// File: rtl/wiper_cnt_reg.sv
module wiper_cnt_reg
   import wiper_pkg::*;
#(
   parameter int CNT_W = 6,
   localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rst_val,
   input  logic             xfer_en,
   input  logic [CNT_W-1:0] xfer_val,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             step,
   input  logic             step_up,
   output logic [CNT_W-1:0] pos
);
   wiper_src_e       src;
   logic [CNT_W-1:0] stepped;

   always_comb begin
      if (!rst_n)       src = SRC_RESET;
      else if (xfer_en) src = SRC_XFER;
      else if (wr_en)   src = SRC_WRITE;
      else if (step)    src = SRC_STEP;
      else              src = SRC_HOLD;
   end

   // Saturating single step toward the chosen end
   always_comb begin
      stepped = pos;
      if (step_up && pos != TOP_VAL)               stepped = pos + 1'b1;
      else if (!step_up && pos != '0)              stepped = pos - 1'b1;
   end

   always_ff @(posedge clk) begin
      unique case (src)
         SRC_RESET: pos <= rst_val;
         SRC_XFER:  pos <= xfer_val;
         SRC_WRITE: pos <= wr_val;
         SRC_STEP:  pos <= stepped;
         default:   pos <= pos;
      endcase
   end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
   parameter int CNT_W   = 6,
   localparam int NTAP   = 1 << CNT_W
) (
   input  logic [CNT_W-1:0] pos,
   output logic [NTAP-1:0]  tap_sel
);
   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign tap_sel[i] = (pos == CNT_W'(i));
   end
endmodule

// File: rtl/wiper_counter_top.sv
module wiper_counter_top #(
   parameter int CNT_W    = 6,
   parameter int NUM_DREG = 4,
   localparam int SEL_W   = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1,
   localparam int NTAP    = 1 << CNT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step_en,
   input  logic                      scl,
   input  logic                      sda,
   input  logic                      wr_en,
   input  logic [CNT_W-1:0]          wr_data,
   input  logic                      xfer_en,
   input  logic [SEL_W-1:0]          xfer_sel,
   input  logic [NUM_DREG*CNT_W-1:0] dreg_bus,
   output logic [CNT_W-1:0]          wiper_pos,
   output logic [NTAP-1:0]           tap_sel
);
   if (CNT_W < 1 || CNT_W > 10) begin : g_bad_width
      $error("wiper_counter_top: CNT_W must be within 1..10");
   end
   if (NUM_DREG < 1) begin : g_bad_dreg
      $error("wiper_counter_top: NUM_DREG must be at least 1");
   end

   logic             step_pulse;
   logic             step_up;
   logic [CNT_W-1:0] sel_val;
   logic [CNT_W-1:0] zero_val;

   wiper_step_detect u_step (
      .clk        (clk),
      .scl        (scl),
      .sda        (sda),
      .step_en    (step_en),
      .step_pulse (step_pulse),
      .step_up    (step_up)
   );

   wiper_dreg_mux #(.CNT_W(CNT_W), .NUM_DREG(NUM_DREG)) u_mux (
      .dreg_bus (dreg_bus),
      .sel      (xfer_sel),
      .sel_val  (sel_val),
      .zero_val (zero_val)
   );

   wiper_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_val  (zero_val),
      .xfer_en  (xfer_en),
      .xfer_val (sel_val),
      .wr_en    (wr_en),
      .wr_val   (wr_data),
      .step     (step_pulse),
      .step_up  (step_up),
      .pos      (wiper_pos)
   );

   wiper_tap_decode #(.CNT_W(CNT_W)) u_dec (
      .pos     (wiper_pos),
      .tap_sel (tap_sel)
   );
endmodule

// File: rtl/wiper_counter_chk.sv
module wiper_counter_chk #(
   parameter int CNT_W    = 6,
   parameter int NUM_DREG = 4,
   localparam int SEL_W   = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1,
   localparam int NTAP    = 1 << CNT_W,
   localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}}
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      sda,
   input logic                      wr_en,
   input logic [CNT_W-1:0]          wr_data,
   input logic                      xfer_en,
   input logic [SEL_W-1:0]          xfer_sel,
   input logic [NUM_DREG*CNT_W-1:0] dreg_bus,
   input logic                      step_pulse,
   input logic [CNT_W-1:0]          wiper_pos,
   input logic [NTAP-1:0]           tap_sel
);
   assert_reset_load_R1: assert property (@(posedge clk)
      !rst_n |=> wiper_pos == $past(dreg_bus[CNT_W-1:0]));

   assert_one_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel) == 1 && tap_sel[wiper_pos]);

   assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !xfer_en) |=> wiper_pos == $past(wr_data));

   assert_xfer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_en |=> wiper_pos == $past(dreg_bus[xfer_sel*CNT_W +: CNT_W]));

   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_pulse && sda && !xfer_en && !wr_en && wiper_pos != TOP_VAL)
      |=> wiper_pos == $past(wiper_pos) + 1'b1);

   assert_top_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_pulse && sda && !xfer_en && !wr_en && wiper_pos == TOP_VAL)
      |=> wiper_pos == TOP_VAL);

   assert_bottom_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_pulse && !sda && !xfer_en && !wr_en && wiper_pos == '0)
      |=> wiper_pos == '0);

   // R7 and R8: with no load and no qualified edge, the position holds
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_pulse && !xfer_en && !wr_en) |=> $stable(wiper_pos));
endmodule

bind wiper_counter_top wiper_counter_chk #(.CNT_W(CNT_W), .NUM_DREG(NUM_DREG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sda        (sda),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .xfer_en    (xfer_en),
   .xfer_sel   (xfer_sel),
   .dreg_bus   (dreg_bus),
   .step_pulse (step_pulse),
   .wiper_pos  (wiper_pos),
   .tap_sel    (tap_sel)
);

// File: tb/wiper_counter_top_bench.sv
`timescale 1ns/1ps
module wiper_counter_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_en = 1'b0;
   logic        scl = 1'b0;
   logic        sda = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_data = '0;
   logic        xfer_en = 1'b0;
   logic [1:0]  xfer_sel = '0;
   logic [23:0] dreg_bus = '0;
   logic [5:0]  wiper_pos;
   logic [63:0] tap_sel;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 0;
   logic [5:0] model = '0;

   always #5 clk = ~clk;

   wiper_counter_top u_wiper_counter_top (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .scl(scl), .sda(sda),
      .wr_en(wr_en), .wr_data(wr_data), .xfer_en(xfer_en), .xfer_sel(xfer_sel),
      .dreg_bus(dreg_bus), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
   );

   function automatic logic [5:0] sat_step(logic [5:0] p, logic up);
      if (up)  return (p == 6'd63) ? p : p + 6'd1;
      else     return (p == 6'd0)  ? p : p - 6'd1;
   endfunction

   function automatic logic [5:0] dreg_field(logic [23:0] bus, int k);
      return bus[k*6 +: 6];
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(string req);
      n_checks++;
      if (wiper_pos !== model) begin
         n_errors++;
         $display("FAIL %s: wiper_pos=%0d expected %0d", req, wiper_pos, model);
      end
      n_checks++;
      if (tap_sel !== (64'd1 << model)) begin
         n_errors++;
         $display("FAIL R2 (%s): tap_sel=%h expected %h", req, tap_sel, 64'd1 << model);
      end
   endtask

   task automatic do_reset(logic [23:0] regs);
      dreg_bus = regs; rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      model = dreg_field(regs, 0);
      tick();
   endtask

   task automatic do_write(logic [5:0] v);
      wr_en = 1'b1; wr_data = v;
      tick();
      wr_en = 1'b0;
      model = v;
   endtask

   task automatic do_xfer(logic [1:0] s);
      xfer_en = 1'b1; xfer_sel = s;
      tick();
      xfer_en = 1'b0;
      model = dreg_field(dreg_bus, int'(s));
   endtask

   task automatic do_step(logic up, int high_cycles);
      sda = up; scl = 1'b1;
      for (int i = 0; i < high_cycles; i++) tick();
      scl = 1'b0;
      tick();
      if (step_en) model = sat_step(model, up);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20517));
      tick();
      // R1: reset loads register zero
      do_reset({6'd9, 6'd40, 6'd17, 6'd33});
      check("R1 reset load");

      // R3: host write
      do_write(6'd62);
      check("R3 write");

      // R5 / R6: step up toward the top and saturate
      step_en = 1'b1;
      do_step(1'b1, 1); check("R5 step up");
      do_step(1'b1, 1); check("R6 top saturate");
      do_step(1'b0, 1); check("R5 step down");

      do_write(6'd1);
      do_step(1'b0, 1); check("R5 down to zero");
      do_step(1'b0, 1); check("R6 bottom saturate");

      // R7: long high is one step; sda flip while high ignored
      do_write(6'd20);
      do_step(1'b1, 6); check("R7 long pulse one step");
      sda = 1'b1; scl = 1'b1; tick();
      sda = 1'b0; tick(); tick();
      scl = 1'b0; tick();
      model = sat_step(model, 1'b1);
      check("R7 direction at rise");

      // R8: steps ignored outside step mode
      step_en = 1'b0;
      do_step(1'b1, 1); do_step(1'b1, 2);
      check("R8 disabled pulses");
      step_en = 1'b1;

      // R4: each data register
      for (int k = 0; k < 4; k++) begin
         do_xfer(2'(k));
         check("R4 xfer");
      end

      // R9: transfer beats write
      xfer_en = 1'b1; xfer_sel = 2'd2; wr_en = 1'b1; wr_data = 6'd5;
      tick();
      xfer_en = 1'b0; wr_en = 1'b0;
      model = dreg_field(dreg_bus, 2);
      check("R9 xfer over write");

      // R9: write beats step
      wr_en = 1'b1; wr_data = 6'd44; sda = 1'b1; scl = 1'b1;
      tick();
      wr_en = 1'b0; scl = 1'b0;
      tick();
      model = 6'd44;
      check("R9 write over step");

      // R9: reset beats transfer
      rst_n = 1'b0; xfer_en = 1'b1; xfer_sel = 2'd1;
      tick();
      rst_n = 1'b1; xfer_en = 1'b0;
      model = dreg_field(dreg_bus, 0);
      tick();
      check("R9 reset over xfer");

      // Random mix
      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: do_write(6'($urandom));
            1: begin dreg_bus = 24'($urandom); do_xfer(2'($urandom)); end
            2: do_step(1'($urandom), int'($urandom_range(1, 3)));
            3: begin step_en = 1'($urandom); do_step(1'($urandom), 1); end
            4: do_step(1'b1, 1);
            default: do_step(1'b0, 1);
         endcase
         check("R5 random mix");
         step_en = 1'b1;
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule